// File: doc/BRIEF.md
# SPI Flash Write-Protection Gate

This block sits between the registers that software uses to request SPI flash commands and the engine that runs the serial cycles. Software loads an address and an opcode slot, then pulses `go`. The gate takes a private copy of both values and checks them against two protection schemes. It then either hands the command to the cycle engine or drops it.

The first scheme covers address windows. The second is a global write switch. Both act only on opcodes that a programmable type table marks as writes. A command is dropped if either scheme objects. A dropped command still reports completion to software, and it also sets a sticky blocked flag. A lock bit freezes the windows, the type table and the lock bit itself until reset.

Registers are written through a simple select/data port, and nothing is read back through it. Select codes: `2*i` is the base of window i, `2*i+1` is its limit, 4 holds the window enables (bit i for window i), 5 is the opcode type table (bit s set means slot s is a write), 6 is control (bit 0 allows writes globally, bit 1 is the lock), 7 is status (writing bit 0 as 1 clears the blocked flag), 8 is the request address, and 9 is the request command (bits 2:0 select the slot, bit 3 marks an atomic command that needs a prefix).

Top module: `spi_wp_gate`

## Requirements
- R1: A command whose slot has a 0 in the type table is issued whatever the window and global settings are.
- R2: While control bit 0 is 0, every write-type command is blocked. While it is 1, the global scheme blocks nothing.
- R3: A write-type command whose start address satisfies base <= address <= limit for an enabled window is blocked. Both bounds are inclusive.
- R4: A window that is disabled, or whose base is greater than its limit, blocks nothing.
- R5: Only the start address is compared. An address one below a window's base passes.
- R6: The command is blocked when either scheme blocks it. The two schemes are combined with OR.
- R7: Once the lock bit (control bit 1) is set, writes to the window registers, the enable register, the type table and the lock bit have no effect until reset. The global allow bit stays writable.
- R8: The address and opcode slot are copied on the clock edge that accepts `go`. The decision and the issued command use only this copy.
- R9: A blocked atomic command issues nothing to the engine, including its prefix. An allowed atomic command is issued with `eng_atomic` high.
- R10: A blocked command raises `sw_done` and `blk_pulse` for exactly one cycle, sets `blk_sticky`, and does not raise `eng_go`.
- R11: `blk_sticky` is cleared by reset and by writing 1 to status bit 0.
- R12: `eng_go` or the blocked result appears on the second clock edge after `go` is sampled and lasts one cycle. `sw_done` follows on the edge that samples `eng_done`. A `go` that arrives while the gate is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 32 | Register write data |
| go | input | 1 | Request to run the loaded command |
| eng_done | input | 1 | Cycle engine has finished the issued command |
| eng_go | output | 1 | One-cycle start to the cycle engine |
| eng_slot | output | 3 | Latched opcode slot |
| eng_addr | output | 24 | Latched start address |
| eng_atomic | output | 1 | Issue the prefix opcode before the command |
| busy | output | 1 | A request is being checked or is running |
| sw_done | output | 1 | One-cycle completion pulse to software |
| blk_pulse | output | 1 | One-cycle pulse when a command is blocked |
| blk_sticky | output | 1 | Sticky blocked-access status |

## Verification
The bench probes both inclusive edges of a window, an address just below the base, and a window whose base is above its limit. A comparator with an off-by-one error, a missing inverted-window guard, or a check of a range end instead of the start would flip the block/pass result in these vectors. It rewrites the request address in the cycle after `go`; a gate that reads the live register instead of its copy issues the new address and reaches the wrong decision. It also blocks an atomic write and drives late `go` pulses while busy; a gate that leaks the prefix or accepts a second request shows an extra `eng_go`. It then tries to overwrite locked registers and to clear the lock, which a weak lock would allow, and it checks that reset alone releases the lock.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
    parameter int ADDR_W     = 24;
    parameter int NUM_WIN    = 2;
    parameter int SLOT_W     = 3;
    parameter int DATA_W     = 32;
    localparam int NUM_SLOTS = 1 << SLOT_W;
    localparam int SEL_EN    = 2 * NUM_WIN;
    localparam int SEL_TYPE  = SEL_EN + 1;
    localparam int SEL_CTRL  = SEL_EN + 2;
    localparam int SEL_STAT  = SEL_EN + 3;
    localparam int SEL_ADDR  = SEL_EN + 4;
    localparam int SEL_CMD   = SEL_EN + 5;
    localparam int SEL_W     = $clog2(SEL_CMD + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              en;
    } win_t;

    typedef struct packed {
        win_t [NUM_WIN-1:0]   win;
        logic [NUM_SLOTS-1:0] is_write;
        logic                 wr_allow;
        logic                 locked;
    } prot_cfg_t;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [ADDR_W-1:0] addr;
        logic              atomic;
    } cmd_t;

    typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_RUN} gate_st_t;

    function automatic logic win_hit(input win_t w, input logic [ADDR_W-1:0] a);
        return w.en && (w.base <= w.limit) && (a >= w.base) && (a <= w.limit);
    endfunction
endpackage

// File: rtl/spi_wp_regs.sv
module spi_wp_regs
    import spi_wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              blk_set,
    output prot_cfg_t         cfg,
    output cmd_t              live_cmd,
    output logic              blk_sticky
);
    logic [ADDR_W-1:0]    base_q [NUM_WIN];
    logic [ADDR_W-1:0]    lim_q  [NUM_WIN];
    logic [NUM_WIN-1:0]   en_q;
    logic [NUM_SLOTS-1:0] type_q;
    logic                 allow_q, lock_q, sticky_q;
    logic                 open_wr;

    assign open_wr = wr_en && !lock_q;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i] <= '0;
                lim_q[i]  <= '0;
            end else if (open_wr) begin
                if (wr_sel == SEL_W'(2*i))   base_q[i] <= wr_data[ADDR_W-1:0];
                if (wr_sel == SEL_W'(2*i+1)) lim_q[i]  <= wr_data[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            type_q   <= '0;
            allow_q  <= 1'b0;
            lock_q   <= 1'b0;
            sticky_q <= 1'b0;
            live_cmd <= '0;
        end else begin
            if (open_wr && wr_sel == SEL_W'(SEL_EN))   en_q   <= wr_data[NUM_WIN-1:0];
            if (open_wr && wr_sel == SEL_W'(SEL_TYPE)) type_q <= wr_data[NUM_SLOTS-1:0];
            if (wr_en && wr_sel == SEL_W'(SEL_CTRL)) begin
                allow_q <= wr_data[0];
                if (!lock_q) lock_q <= wr_data[1];
            end
            if (wr_en && wr_sel == SEL_W'(SEL_ADDR)) live_cmd.addr <= wr_data[ADDR_W-1:0];
            if (wr_en && wr_sel == SEL_W'(SEL_CMD)) begin
                live_cmd.slot   <= wr_data[SLOT_W-1:0];
                live_cmd.atomic <= wr_data[SLOT_W];
            end
            if (blk_set)
                sticky_q <= 1'b1;
            else if (wr_en && wr_sel == SEL_W'(SEL_STAT) && wr_data[0])
                sticky_q <= 1'b0;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_WIN; i++) begin
            cfg.win[i].base  = base_q[i];
            cfg.win[i].limit = lim_q[i];
            cfg.win[i].en    = en_q[i];
        end
        cfg.is_write = type_q;
        cfg.wr_allow = allow_q;
        cfg.locked   = lock_q;
    end
    assign blk_sticky = sticky_q;

    p_lock_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q && $stable(type_q) && $stable(en_q) && $stable(base_q[0]) && $stable(lim_q[0]));
    p_sticky_set_r10: assert property (@(posedge clk) disable iff (rst)
        blk_set |=> sticky_q);
endmodule

// File: rtl/spi_wp_check.sv
module spi_wp_check
    import spi_wp_pkg::*;
(
    input  prot_cfg_t cfg,
    input  cmd_t      cmd,
    output logic      block
);
    logic [NUM_WIN-1:0] hit;
    logic               is_wr;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_hit
        assign hit[i] = win_hit(cfg.win[i], cmd.addr);
    end

    assign is_wr = cfg.is_write[cmd.slot];
    assign block = is_wr && ((|hit) || !cfg.wr_allow);
endmodule

// File: rtl/spi_wp_seq.sv
module spi_wp_seq
    import spi_wp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  cmd_t live_cmd,
    input  logic block,
    input  logic eng_done,
    output cmd_t snap,
    output logic eng_go,
    output logic sw_done,
    output logic blk_pulse,
    output logic busy
);
    gate_st_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            snap      <= '0;
            eng_go    <= 1'b0;
            sw_done   <= 1'b0;
            blk_pulse <= 1'b0;
        end else begin
            eng_go    <= 1'b0;
            sw_done   <= 1'b0;
            blk_pulse <= 1'b0;
            unique case (st)
                ST_IDLE: if (go) begin
                    snap <= live_cmd;
                    st   <= ST_CHECK;
                end
                ST_CHECK: if (block) begin
                    sw_done   <= 1'b1;
                    blk_pulse <= 1'b1;
                    st        <= ST_IDLE;
                end else begin
                    eng_go <= 1'b1;
                    st     <= ST_RUN;
                end
                ST_RUN: if (eng_done) begin
                    sw_done <= 1'b1;
                    st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st != ST_IDLE);

    p_go_one_cycle_r12: assert property (@(posedge clk) disable iff (rst)
        eng_go |=> !eng_go);
    p_go_after_check_r12: assert property (@(posedge clk) disable iff (rst)
        eng_go |-> $past(st) == ST_CHECK);
    p_block_reports_r10: assert property (@(posedge clk) disable iff (rst)
        blk_pulse |-> sw_done && !eng_go);
    p_snap_held_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> $stable(snap));
endmodule

// File: rtl/spi_wp_gate.sv
module spi_wp_gate
    import spi_wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              go,
    input  logic              eng_done,
    output logic              eng_go,
    output logic [SLOT_W-1:0] eng_slot,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              eng_atomic,
    output logic              busy,
    output logic              sw_done,
    output logic              blk_pulse,
    output logic              blk_sticky
);
    prot_cfg_t cfg;
    cmd_t      live_cmd, snap;
    logic      block;

    spi_wp_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .blk_set(blk_pulse), .cfg(cfg), .live_cmd(live_cmd), .blk_sticky(blk_sticky)
    );

    spi_wp_check u_check (.cfg(cfg), .cmd(snap), .block(block));

    spi_wp_seq u_seq (
        .clk(clk), .rst(rst), .go(go), .live_cmd(live_cmd), .block(block),
        .eng_done(eng_done), .snap(snap), .eng_go(eng_go), .sw_done(sw_done),
        .blk_pulse(blk_pulse), .busy(busy)
    );

    assign eng_slot   = snap.slot;
    assign eng_addr   = snap.addr;
    assign eng_atomic = snap.atomic;

    p_read_never_blocked_r1: assert property (@(posedge clk) disable iff (rst)
        blk_pulse |-> $past(cfg.is_write[snap.slot]));
endmodule

// File: tb/spi_wp_gate_test.sv
module spi_wp_gate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst = 1'b1;
    logic        wr_en = 1'b0, go = 1'b0, eng_done = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        eng_go, eng_atomic, busy, sw_done, blk_pulse, blk_sticky;
    logic [2:0]  eng_slot;
    logic [23:0] eng_addr;
    int checks = 0, errors = 0;

    spi_wp_gate uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .go(go), .eng_done(eng_done), .eng_go(eng_go), .eng_slot(eng_slot),
        .eng_addr(eng_addr), .eng_atomic(eng_atomic), .busy(busy), .sw_done(sw_done),
        .blk_pulse(blk_pulse), .blk_sticky(blk_sticky)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [2:0]  slot;
        logic [23:0] addr;
        logic        atomic;
        logic        exp_blk;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 24'h001500, 1'b0, 1'b0},   // R1 read inside window
        '{3'd1, 24'h001000, 1'b0, 1'b1},   // R3 lower bound
        '{3'd1, 24'h001FFF, 1'b0, 1'b1},   // R3 upper bound
        '{3'd1, 24'h000FFF, 1'b0, 1'b0},   // R5 one below base
        '{3'd1, 24'h002000, 1'b0, 1'b0},   // R3 one above limit
        '{3'd1, 24'h007800, 1'b0, 1'b0},   // R4 inverted window
        '{3'd2, 24'h001800, 1'b1, 1'b1},   // R9 blocked atomic
        '{3'd2, 24'h003000, 1'b1, 1'b0}    // R9 allowed atomic
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Loads a command, runs it, checks the outcome at the ports.
    task automatic run(input logic [2:0] slot, input logic [23:0] addr, input logic atomic,
                       input logic exp_blk, input string req);
        wr(4'd8, {8'h0, addr});
        wr(4'd9, {28'h0, atomic, slot});
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;            // edge E0 took go
        chk(busy === 1'b1, req, "busy after go", 32'(busy), 1);
        @(negedge clk);                       // after E1: decision
        chk(eng_go === !exp_blk, req, "eng_go", 32'(eng_go), 32'(!exp_blk));
        chk(blk_pulse === exp_blk, req, "blk_pulse", 32'(blk_pulse), 32'(exp_blk));
        if (exp_blk) begin
            chk(sw_done === 1'b1, req, "sw_done on block", 32'(sw_done), 1);
            @(negedge clk);
            chk(blk_sticky === 1'b1 && blk_pulse === 1'b0 && sw_done === 1'b0,
                req, "sticky set, pulses end", {blk_sticky, blk_pulse, sw_done}, 3'b100);
        end else begin
            chk(eng_addr === addr && eng_slot === slot && eng_atomic === atomic, req,
                "issued cmd", {eng_atomic, eng_slot, eng_addr}, {atomic, slot, addr});
            eng_done = 1'b1;
            @(negedge clk); eng_done = 1'b0;
            chk(sw_done === 1'b1 && busy === 1'b0, req, "done after ack",
                {sw_done, busy}, 2'b10);
        end
        wr(4'd7, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({eng_go, busy, sw_done, blk_pulse, blk_sticky} === 5'b0, "R11", "reset outputs",
            {eng_go, busy, sw_done, blk_pulse, blk_sticky}, 0);
        // R2 defaults: allow=0, table empty -> read passes
        run(3'd1, 24'h000010, 1'b0, 1'b0, "R1");
        wr(4'd5, 32'h06);            // slots 1,2 are writes
        run(3'd1, 24'h000010, 1'b0, 1'b1, "R2");
        wr(4'd0, 32'h001000); wr(4'd1, 32'h001FFF);
        wr(4'd2, 32'h008000); wr(4'd3, 32'h007000);
        wr(4'd4, 32'h3);
        wr(4'd6, 32'h1);             // allow writes
        for (int i = 0; i < NV; i++)
            run(VECS[i].slot, VECS[i].addr, VECS[i].atomic, VECS[i].exp_blk,
                VECS[i].exp_blk ? "R3" : "R4");
        // R6: global off blocks write outside windows; read still passes
        wr(4'd6, 32'h0);
        run(3'd1, 24'h003000, 1'b0, 1'b1, "R6");
        run(3'd0, 24'h001500, 1'b0, 1'b0, "R1");
        wr(4'd6, 32'h1);
        // R11: sticky set then W1C; write of 0 does not clear
        run(3'd1, 24'h001000, 1'b0, 1'b1, "R11");   // run ends with clear
        chk(blk_sticky === 1'b0, "R11", "W1C clears", 32'(blk_sticky), 0);
        // R8: change the address right after go
        wr(4'd8, 32'h003000); wr(4'd9, 32'h1);
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0; wr_en = 1'b1; wr_sel = 4'd8; wr_data = 32'h001100;
        @(negedge clk); wr_en = 1'b0;
        chk(eng_go === 1'b1 && eng_addr === 24'h003000, "R8", "snapshot addr",
            {8'h0, eng_addr}, 32'h003000);
        // R12: go while busy ignored
        go = 1'b1;
        @(negedge clk); @(negedge clk); go = 1'b0;
        chk(eng_go === 1'b0 && busy === 1'b1, "R12", "no restart while busy",
            {eng_go, busy}, 2'b01);
        eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        chk(sw_done === 1'b1, "R12", "sw_done after ack", 32'(sw_done), 1);
        @(negedge clk);
        chk(busy === 1'b0 && eng_go === 1'b0, "R12", "idle, single issue",
            {busy, eng_go}, 0);
        // R7: lock, then try to disarm
        wr(4'd6, 32'h3);
        wr(4'd4, 32'h0); wr(4'd5, 32'h0); wr(4'd0, 32'h005000); wr(4'd6, 32'h1);
        run(3'd1, 24'h001000, 1'b0, 1'b1, "R7");
        run(3'd1, 24'h005000, 1'b0, 1'b0, "R7");
        wr(4'd6, 32'h2);             // allow writable under lock
        run(3'd1, 24'h005000, 1'b0, 1'b1, "R7");
        // reset releases lock and clears sticky
        run(3'd1, 24'h005000, 1'b0, 1'b1, "R7");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(blk_sticky === 1'b0, "R11", "reset clears sticky", 32'(blk_sticky), 0);
        wr(4'd5, 32'h02); wr(4'd6, 32'h1); wr(4'd0, 32'h000100);
        wr(4'd1, 32'h000200); wr(4'd4, 32'h1);
        run(3'd1, 24'h000150, 1'b0, 1'b1, "R7");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule